// File: doc/BRIEF.md
# Fractional-Period Dithered Two-Phase PWM Generator

This block drives two complementary PWM outputs from a free-running clock. One PWM cycle is built from four consecutive phases: an active phase for output A, a dead interval, an active phase for output B, and a closing dead interval. The base period `n` in clocks is the sum of the four 12-bit timing settings. When the integer step between neighbouring periods is too coarse, the block can be told to stretch some cycles by one clock. A 4-bit fraction `d` then selects how many of the 16 cycles in each frame last `n+1` clocks. The average frequency over a frame then lies between the two neighbouring base frequencies, on a grid sixteen times finer than the plain divider gives.

The timing settings, the fraction and the mode select are plain control pins. They have no handshake: the block copies them into shadow registers only when a frame starts, so software or a controller may change them at any time. A one-clock frame-start strobe marks the first clock of every frame. This lets a controller line up updates with the frame or count frames.

Top module: `frac_pwm_gen`

## Requirements
- R1: Each timing setting is a 12-bit unsigned value (0 to 4095). With stretching off, every PWM cycle lasts exactly n = on-time A + dead A + on-time B + dead B clocks.
- R2: With enhanced mode on and fraction d, a frame is 16 cycles numbered 0 to 15. Cycles 0 to d-1 last n+1 clocks, and cycles d to 15 last n clocks.
- R3: When enhanced mode is off, or when d is 0, no cycle is stretched.
- R4: Within a cycle, clock positions count from 0. `pwm_a` is high at positions below on-time A. `pwm_b` is high from position on-time A + dead A for on-time B clocks. Both outputs are low at every other position, and this includes the extra clock of a stretched cycle, which comes last.
- R5: `pwm_a` and `pwm_b` are never high in the same clock.
- R6: `frame_start` is high for exactly one clock, the first clock of cycle 0, and it repeats once every 16 cycles.
- R7: Settings that change during a frame have no effect on that frame. They apply from the next frame on.
- R8: An on-time of zero keeps that output low for the whole cycle, while the cycle still lasts its full length.
- R9: While the latched total period is zero, both outputs and `frame_start` stay low and the settings are re-sampled every clock. When a non-zero total is presented, a frame begins on the following clock.
- R10: After a clock edge that sees `enable` low, both outputs and `frame_start` are low. When `enable` is sampled high from that state, the settings are latched and `frame_start` is high on the following clock.
- R11: While `rst_n` is low, both outputs and `frame_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator when high |
| enh_mode | input | 1 | Enables fractional stretching |
| on_time_a | input | 12 | Active clocks of output A |
| dead_a | input | 12 | Dead clocks after output A |
| on_time_b | input | 12 | Active clocks of output B |
| dead_b | input | 12 | Dead clocks after output B (the stretch clock follows) |
| frac_sel | input | 4 | Number of stretched cycles per frame |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |
| frame_start | output | 1 | One-clock strobe at the first clock of each frame |

## Verification
The last clock of cycle 15 does three things at once: it ends the frame, it reloads the shadow settings, and it decides whether cycle 0 of the new frame is stretched. That decision must use the newly loaded fraction, not the old one. The bench provokes this by changing every setting, fraction included, on the first clock of a frame that runs with no stretch. It then compares the rest of that frame against the old settings and the whole following frame, clock by clock, against the new ones, including the length of its first cycle. Turning `enable` off on the very clock of a frame strobe is the second collision, and it is judged by the outputs going low on the next clock.

// File: rtl/frac_pwm_pkg.sv
package frac_pwm_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/frac_pwm_shadow.sv
// Shadow copy of the timing settings, taken only when load is high.
// Phase boundaries are pre-added here so the position compare stays shallow.
module frac_pwm_shadow #(
  parameter int TW = 12,
  parameter int FW = 4,
  localparam int PW = TW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] in_on_a,
  input  logic [TW-1:0] in_dead_a,
  input  logic [TW-1:0] in_on_b,
  input  logic [TW-1:0] in_dead_b,
  input  logic [FW-1:0] in_frac,
  input  logic          in_enh,
  output logic [PW-1:0] a_end,
  output logic [PW-1:0] b_lo,
  output logic [PW-1:0] b_hi,
  output logic [PW-1:0] period,
  output logic [FW-1:0] frac,
  output logic          enh
);
  logic [PW-1:0] sum_a, sum_ad, sum_adb, sum_all;

  always_comb begin
    sum_a   = PW'(in_on_a);
    sum_ad  = sum_a + PW'(in_dead_a);
    sum_adb = sum_ad + PW'(in_on_b);
    sum_all = sum_adb + PW'(in_dead_b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_end  <= '0;
      b_lo   <= '0;
      b_hi   <= '0;
      period <= '0;
      frac   <= '0;
      enh    <= 1'b0;
    end else if (load) begin
      a_end  <= sum_a;
      b_lo   <= sum_ad;
      b_hi   <= sum_adb;
      period <= sum_all;
      frac   <= in_frac;
      enh    <= in_enh;
    end
  end
endmodule

// File: rtl/frac_pwm_dither.sv
// Decides whether the current cycle of the frame carries the extra clock.
module frac_pwm_dither #(
  parameter int FW = 4
) (
  input  logic [FW-1:0] cyc,
  input  logic [FW-1:0] frac,
  input  logic          enh,
  output logic          stretch
);
  always_comb stretch = enh && (cyc < frac);
endmodule

// File: rtl/frac_pwm_seq.sv
// Position-in-cycle and cycle-in-frame counters plus reload control.
module frac_pwm_seq
  import frac_pwm_pkg::*;
#(
  parameter int TW = 12,
  parameter int FW = 4,
  localparam int PW = TW + 2,
  localparam logic [FW-1:0] LAST_CYC = {FW{1'b1}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [PW-1:0] period,
  input  logic          stretch,
  output logic          load,
  output logic          run,
  output logic          period_nz,
  output logic [PW-1:0] pos,
  output logic [FW-1:0] cyc,
  output logic          frame_start
);
  run_state_e    state;
  logic [PW-1:0] len_m1;
  logic          at_end;
  logic          frame_end;

  always_comb begin
    run         = (state == ST_RUN);
    period_nz   = (period != '0);
    len_m1      = period + PW'(stretch) - PW'(1);
    at_end      = run && period_nz && (pos == len_m1);
    frame_end   = at_end && (cyc == LAST_CYC);
    load        = enable && (!run || !period_nz || frame_end);
    frame_start = run && period_nz && (pos == '0) && (cyc == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pos   <= '0;
      cyc   <= '0;
    end else if (!enable) begin
      state <= ST_IDLE;
      pos   <= '0;
      cyc   <= '0;
    end else if (!run) begin
      state <= ST_RUN;
      pos   <= '0;
      cyc   <= '0;
    end else if (!period_nz) begin
      pos <= '0;
      cyc <= '0;
    end else if (at_end) begin
      pos <= '0;
      cyc <= cyc + FW'(1);
    end else begin
      pos <= pos + PW'(1);
    end
  end
endmodule

// File: rtl/frac_pwm_outmux.sv
// Decodes the position within the cycle into the two PWM levels.
module frac_pwm_outmux #(
  parameter int PW = 14
) (
  input  logic          run,
  input  logic          period_nz,
  input  logic [PW-1:0] pos,
  input  logic [PW-1:0] a_end,
  input  logic [PW-1:0] b_lo,
  input  logic [PW-1:0] b_hi,
  output logic          pwm_a,
  output logic          pwm_b
);
  logic live;

  always_comb begin
    live  = run && period_nz;
    pwm_a = live && (pos < a_end);
    pwm_b = live && (pos >= b_lo) && (pos < b_hi);
  end
endmodule

// File: rtl/frac_pwm_gen.sv
module frac_pwm_gen #(
  parameter int TW = 12,
  parameter int FW = 4,
  localparam int PW = TW + 2,
  localparam int SBW = 4 * PW + FW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          enh_mode,
  input  logic [TW-1:0] on_time_a,
  input  logic [TW-1:0] dead_a,
  input  logic [TW-1:0] on_time_b,
  input  logic [TW-1:0] dead_b,
  input  logic [FW-1:0] frac_sel,
  output logic          pwm_a,
  output logic          pwm_b,
  output logic          frame_start
);
  logic [PW-1:0]  a_end_w, b_lo_w, b_hi_w, period_w, pos_w;
  logic [FW-1:0]  frac_w, cyc_w;
  logic           enh_w, load_w, run_w, nz_w, stretch_w;
  logic [SBW-1:0] shadow_bus;

  frac_pwm_shadow #(.TW(TW), .FW(FW)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_w),
    .in_on_a   (on_time_a),
    .in_dead_a (dead_a),
    .in_on_b   (on_time_b),
    .in_dead_b (dead_b),
    .in_frac   (frac_sel),
    .in_enh    (enh_mode),
    .a_end     (a_end_w),
    .b_lo      (b_lo_w),
    .b_hi      (b_hi_w),
    .period    (period_w),
    .frac      (frac_w),
    .enh       (enh_w)
  );

  frac_pwm_dither #(.FW(FW)) u_dither (
    .cyc     (cyc_w),
    .frac    (frac_w),
    .enh     (enh_w),
    .stretch (stretch_w)
  );

  frac_pwm_seq #(.TW(TW), .FW(FW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .period      (period_w),
    .stretch     (stretch_w),
    .load        (load_w),
    .run         (run_w),
    .period_nz   (nz_w),
    .pos         (pos_w),
    .cyc         (cyc_w),
    .frame_start (frame_start)
  );

  frac_pwm_outmux #(.PW(PW)) u_outmux (
    .run       (run_w),
    .period_nz (nz_w),
    .pos       (pos_w),
    .a_end     (a_end_w),
    .b_lo      (b_lo_w),
    .b_hi      (b_hi_w),
    .pwm_a     (pwm_a),
    .pwm_b     (pwm_b)
  );

  assign shadow_bus = {a_end_w, b_lo_w, b_hi_w, period_w, frac_w, enh_w};
endmodule

// File: rtl/frac_pwm_checker.sv
module frac_pwm_checker #(
  parameter int TW = 12,
  parameter int FW = 4,
  localparam int PW = TW + 2,
  localparam int SBW = 4 * PW + FW + 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           enable,
  input logic           pwm_a,
  input logic           pwm_b,
  input logic           frame_start,
  input logic           load,
  input logic           run,
  input logic [PW-1:0]  period,
  input logic [SBW-1:0] shadow_bus
);
  // R5: the two outputs are mutually exclusive
  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwm_a && pwm_b));

  // R6: the strobe never lasts two clocks
  p_strobe_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  // R7: shadow settings move only on a load
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(shadow_bus));

  // R9: zero latched period keeps everything quiet
  p_zero_period_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && period == '0) |-> (!pwm_a && !pwm_b && !frame_start));

  // R10: disabling silences outputs on the next clock
  p_enable_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!pwm_a && !pwm_b && !frame_start));

  // R10: a run start with a non-zero setting begins with a strobe
  p_start_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !run) |=> (run && (period == '0 || frame_start)));

  // R11: quiet outputs in reset
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r11: assert (!pwm_a && !pwm_b && !frame_start)
        else $error("outputs active during reset");
    end
  end
endmodule

bind frac_pwm_gen frac_pwm_checker #(.TW(TW), .FW(FW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .pwm_a       (pwm_a),
  .pwm_b       (pwm_b),
  .frame_start (frame_start),
  .load        (load_w),
  .run         (run_w),
  .period      (period_w),
  .shadow_bus  (shadow_bus)
);

// File: tb/frac_pwm_gen_bench.sv
module frac_pwm_gen_bench;
  localparam int TW = 12;
  localparam int FW = 4;
  localparam int FRAME = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic enh = 1'b0;
  logic [TW-1:0] on_a = '0, dd_a = '0, on_b = '0, dd_b = '0;
  logic [FW-1:0] frac = '0;
  logic pwm_a, pwm_b, fs;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  frac_pwm_gen #(.TW(TW), .FW(FW)) u_frac_pwm_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .enh_mode    (enh),
    .on_time_a   (on_a),
    .dead_a      (dd_a),
    .on_time_b   (on_b),
    .dead_b      (dd_b),
    .frac_sel    (frac),
    .pwm_a       (pwm_a),
    .pwm_b       (pwm_b),
    .frame_start (fs)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int a, input int b, input int c, input int d,
                         input int f, input bit e);
    on_a = TW'(a); dd_a = TW'(b); on_b = TW'(c); dd_b = TW'(d);
    frac = FW'(f); enh = e;
  endtask

  task automatic restart();
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic wait_strobe(input string req);
    int n = 0;
    @(negedge clk);
    while (!fs && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(fs == 1'b1, req, "frame start seen", int'(fs), 1);
  endtask

  // Entered at the negedge of the first clock of a frame; returns at the
  // negedge of the first clock of the following frame.
  task automatic check_frame(input int a, input int b, input int c, input int d,
                             input int f, input bit e, input string req);
    int n = a + b + c + d;
    int ea = 0, eb = 0, es = 0, both = 0;
    bit first = 1'b1;
    for (int cy = 0; cy < FRAME; cy++) begin
      int len;
      len = n + ((e && cy < f) ? 1 : 0);
      for (int p = 0; p < len; p++) begin
        bit xa, xb, xs;
        if (!first) @(negedge clk);
        first = 1'b0;
        xa = (p < a);
        xb = (p >= a + b) && (p < a + b + c);
        xs = (cy == 0) && (p == 0);
        if (pwm_a !== xa) ea++;
        if (pwm_b !== xb) eb++;
        if (fs !== xs) es++;
        if (pwm_a && pwm_b) both++;
      end
    end
    chk(ea == 0, req, "pwm_a mismatching clocks", ea, 0);
    chk(eb == 0, req, "pwm_b mismatching clocks", eb, 0);
    chk(es == 0, "R6", "frame_start mismatching clocks", es, 0);
    chk(both == 0, "R5", "clocks with both outputs high", both, 0);
    @(negedge clk);
    chk(fs == 1'b1, "R6", "next frame starts on time", int'(fs), 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!pwm_a && !pwm_b && !fs, "R11", "outputs in reset",
        int'({pwm_a, pwm_b, fs}), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_normal();
    set_cfg(3, 2, 4, 1, 5, 1'b0);
    restart();
    wait_strobe("R1");
    check_frame(3, 2, 4, 1, 5, 1'b0, "R1");
    check_frame(3, 2, 4, 1, 5, 1'b0, "R4");
  endtask

  task automatic t_enhanced();
    set_cfg(3, 2, 4, 1, 5, 1'b1);
    restart();
    wait_strobe("R2");
    check_frame(3, 2, 4, 1, 5, 1'b1, "R2");
  endtask

  task automatic t_frac_zero();
    set_cfg(2, 1, 2, 1, 0, 1'b1);
    restart();
    wait_strobe("R3");
    check_frame(2, 1, 2, 1, 0, 1'b1, "R3");
  endtask

  task automatic t_frac_full();
    set_cfg(1, 1, 1, 1, 15, 1'b1);
    restart();
    wait_strobe("R2");
    check_frame(1, 1, 1, 1, 15, 1'b1, "R2");
  endtask

  task automatic t_zero_on();
    set_cfg(0, 2, 3, 1, 7, 1'b1);
    restart();
    wait_strobe("R8");
    check_frame(0, 2, 3, 1, 7, 1'b1, "R8");
    set_cfg(2, 1, 0, 2, 0, 1'b0);
    restart();
    wait_strobe("R8");
    check_frame(2, 1, 0, 2, 0, 1'b0, "R8");
  endtask

  task automatic t_midframe_and_enable();
    set_cfg(3, 1, 2, 2, 0, 1'b0);
    restart();
    wait_strobe("R7");
    set_cfg(2, 2, 2, 1, 3, 1'b1);
    check_frame(3, 1, 2, 2, 0, 1'b0, "R7");
    check_frame(2, 2, 2, 1, 3, 1'b1, "R7");
    enable = 1'b0;
    @(negedge clk);
    chk(!pwm_a && !pwm_b && !fs, "R10", "outputs after disable",
        int'({pwm_a, pwm_b, fs}), 0);
    repeat (3) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    chk(fs == 1'b1, "R10", "strobe after enable", int'(fs), 1);
    chk(pwm_a == 1'b1, "R10", "pwm_a at restart", int'(pwm_a), 1);
  endtask

  task automatic t_zero_period();
    int hits = 0;
    set_cfg(0, 0, 0, 0, 5, 1'b1);
    restart();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pwm_a || pwm_b || fs) hits++;
    end
    chk(hits == 0, "R9", "active clocks with zero period", hits, 0);
    set_cfg(2, 0, 0, 2, 0, 1'b0);
    @(negedge clk);
    chk(fs == 1'b1, "R9", "strobe after non-zero period", int'(fs), 1);
    check_frame(2, 0, 0, 2, 0, 1'b0, "R9");
  endtask

  task automatic t_wide();
    set_cfg(4095, 0, 0, 1, 1, 1'b1);
    restart();
    wait_strobe("R1");
    check_frame(4095, 0, 0, 1, 1, 1'b1, "R1");
  endtask

  initial begin
    t_reset();
    t_normal();
    t_enhanced();
    t_frac_zero();
    t_frac_full();
    t_zero_on();
    t_midframe_and_enable();
    t_zero_period();
    t_wide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule